// File: doc/BRIEF.md
# Receive Error Collector with Sticky Status and Interrupt

This block gathers the error events that the receive side of an N-lane serial link raises. From them it builds three results. The first is a registered error vector whose width follows the lane count. The second is a set of sticky status bits that software can read. The third is an interrupt line that is masked bit by bit. Per-lane physical-coding errors and per-lane metaframe CRC-32 errors fill the low N bits of the vector. Loss of lane alignment, FIFO overflow and the two ECC outcomes take fixed positions above them.

Two conditions have no place in the vector and are recorded only in status. One is a deskew failure. The other is data that is presented while the ready signal is low. A loss of alignment also sends a one-cycle request back to the link to re-initialize and re-align.

Software uses a two-word register window. Word 0 holds the status bits, and writing 1 to a bit clears it. Word 1 holds the interrupt enables and can be read and written.

Top module: `rxerr_status_top`

## Requirements
- R1: For each lane k below N, error bit k is high in the cycle after the edge that sampled a PCS or CRC-32 strobe on lane k. It is low again one cycle later unless a strobe recurs.
- R2: Error bit N and `realign_req_o` each pulse for one cycle after the edge that sampled `align_lost_i`.
- R3: Error bit N+1 reads 0 in every cycle, whatever the inputs.
- R4: Error bit N+2 follows the `fifo_ovf_i` level with one cycle of delay, and stays high for as long as the level is high.
- R5: Error bit N+3 pulses for one cycle on `ecc_corr_i`, and bit N+4 pulses for one cycle on `ecc_fatal_i`.
- R6: Each event sets a sticky status bit. The bit is readable at address 0 from the cycle after the sampling edge. Layout: bit0 PCS (any lane), bit1 CRC-32 (any lane), bit2 alignment lost, bit3 FIFO overflow, bit4 ECC corrected, bit5 ECC fatal, bit6 deskew fatal, bit7 data while not ready.
- R7: `data_valid_i` high with `ready_i` low sets status bit7. `data_valid_i` high with `ready_i` high leaves bit7 at 0.
- R8: `deskew_fatal_i` sets status bit6 and leaves the error vector all zero.
- R9: A write to address 0 clears every status bit whose write-data bit is 1. Status bits written with 0 keep their value.
- R10: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R11: Address 1 holds the 8-bit interrupt enable and reads back what was written. `irq_o` is high exactly when some status bit and its enable bit are both 1.
- R12: After reset the error vector, `realign_req_o`, `irq_o`, the status bits and the enables are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_pcs_err_i | input | LANES | Per-lane PCS error strobes |
| lane_crc_err_i | input | LANES | Per-lane metaframe CRC-32 error strobes |
| align_lost_i | input | 1 | Loss-of-alignment strobe |
| fifo_ovf_i | input | 1 | Rate FIFO overflow level |
| ecc_corr_i | input | 1 | ECC single-bit corrected strobe |
| ecc_fatal_i | input | 1 | ECC double-bit fatal strobe |
| deskew_fatal_i | input | 1 | Skew beyond deskew range |
| data_valid_i | input | 1 | Receive data valid |
| ready_i | input | 1 | Receive ready from the consumer |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 = status, 1 = interrupt enable |
| reg_wdata_i | input | REG_W | Write data |
| reg_rdata_o | output | REG_W | Read data for `reg_addr_i`, zero-extended |
| err_vec_o | output | LANES+5 | Registered error vector |
| realign_req_o | output | 1 | Re-initialize and re-align request pulse |
| irq_o | output | 1 | Masked interrupt level |

## Verification
A write-1 clear from software can land in the same cycle as a hardware event on the same status bit. The bench provokes this by setting status bit0 and then, in one cycle, writing 1 to bit0 at address 0 while a lane PCS strobe is high. The read-back in the following cycle must still show bit0 set. A second collision comes from lane errors: a PCS strobe and a CRC-32 strobe on the same lane in one cycle must merge into a single bit of the error vector while setting two different status bits.

// File: rtl/rxerr_pkg.sv
`timescale 1ns/1ps
package rxerr_pkg;
    localparam int ST_W = 8;

    localparam int ST_PCS    = 0;
    localparam int ST_CRC    = 1;
    localparam int ST_ALIGN  = 2;
    localparam int ST_OVF    = 3;
    localparam int ST_ECC_C  = 4;
    localparam int ST_ECC_F  = 5;
    localparam int ST_DESKEW = 6;
    localparam int ST_DATA   = 7;

    typedef logic [ST_W-1:0] st_vec_t;
endpackage

// File: rtl/rxerr_event_map.sv
`timescale 1ns/1ps
module rxerr_event_map
    import rxerr_pkg::*;
#(
    parameter int LANES = 4,
    localparam int EW = LANES + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_pcs_err_i,
    input  logic [LANES-1:0] lane_crc_err_i,
    input  logic             align_lost_i,
    input  logic             fifo_ovf_i,
    input  logic             ecc_corr_i,
    input  logic             ecc_fatal_i,
    input  logic             deskew_fatal_i,
    input  logic             data_valid_i,
    input  logic             ready_i,
    output st_vec_t          set_o,
    output logic [EW-1:0]    err_vec_o,
    output logic             realign_req_o
);
    localparam int B_ALIGN = LANES;
    localparam int B_RSV   = LANES + 1;
    localparam int B_OVF   = LANES + 2;
    localparam int B_ECC_C = LANES + 3;
    localparam int B_ECC_F = LANES + 4;

    typedef struct packed {
        logic [EW-1:0] err;
        logic          realign;
    } map_state_t;

    map_state_t st_d, st_q;
    logic [LANES-1:0] lane_any;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_any[k] = lane_pcs_err_i[k] | lane_crc_err_i[k];
    end

    always_comb begin
        st_d                = '0;
        st_d.err[LANES-1:0] = lane_any;
        st_d.err[B_ALIGN]   = align_lost_i;
        st_d.err[B_RSV]     = 1'b0;
        st_d.err[B_OVF]     = fifo_ovf_i;
        st_d.err[B_ECC_C]   = ecc_corr_i;
        st_d.err[B_ECC_F]   = ecc_fatal_i;
        st_d.realign        = align_lost_i;

        set_o            = '0;
        set_o[ST_PCS]    = |lane_pcs_err_i;
        set_o[ST_CRC]    = |lane_crc_err_i;
        set_o[ST_ALIGN]  = align_lost_i;
        set_o[ST_OVF]    = fifo_ovf_i;
        set_o[ST_ECC_C]  = ecc_corr_i;
        set_o[ST_ECC_F]  = ecc_fatal_i;
        set_o[ST_DESKEW] = deskew_fatal_i;
        set_o[ST_DATA]   = data_valid_i & ~ready_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_vec_o     = st_q.err;
    assign realign_req_o = st_q.realign;

    // R1: a lane strobe shows up on its lane bit one cycle later
    p_lane_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_any != '0) |=> (err_vec_o[LANES-1:0] == $past(lane_any)));

    // R2: no realign request without a preceding alignment-loss strobe
    p_realign_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !align_lost_i |=> !realign_req_o);

    // R5: a fatal ECC strobe raises the top error bit in the next cycle
    p_ecc_fatal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_fatal_i |=> err_vec_o[B_ECC_F]);

    // R4: an overflow level that falls takes bit N+2 down one cycle later
    p_ovf_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_ovf_i |=> !err_vec_o[B_OVF]);
endmodule

// File: rtl/rxerr_sticky_regs.sv
`timescale 1ns/1ps
module rxerr_sticky_regs
    import rxerr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  st_vec_t set_i,
    input  logic    wr_i,
    input  logic    addr_i,
    input  st_vec_t wdata_i,
    output st_vec_t status_o,
    output st_vec_t enable_o,
    output logic    irq_o
);
    typedef struct packed {
        st_vec_t status;
        st_vec_t enable;
    } reg_state_t;

    reg_state_t rs_d, rs_q;
    st_vec_t    clr;

    always_comb begin
        clr       = (wr_i && !addr_i) ? wdata_i : '0;
        rs_d      = rs_q;
        // event set has priority over the software clear
        rs_d.status = (rs_q.status & ~clr) | set_i;
        if (wr_i && addr_i) rs_d.enable = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign status_o = rs_q.status;
    assign enable_o = rs_q.enable;
    assign irq_o    = |(rs_q.status & rs_q.enable);

    // R10: every bit that saw an event is set afterwards, clear or not
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i)));

    // R9: bits cleared with no competing event read as 0
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set_i) != '0) |=> ((status_o & $past(clr & ~set_i)) == '0));

    // R6: bits that are not cleared keep their value
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr)) == $past(status_o & ~clr)));
endmodule

// File: rtl/rxerr_status_top.sv
`timescale 1ns/1ps
module rxerr_status_top
    import rxerr_pkg::*;
#(
    parameter int LANES = 4,
    parameter int REG_W = 32,
    localparam int EW = LANES + 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_pcs_err_i,
    input  logic [LANES-1:0] lane_crc_err_i,
    input  logic             align_lost_i,
    input  logic             fifo_ovf_i,
    input  logic             ecc_corr_i,
    input  logic             ecc_fatal_i,
    input  logic             deskew_fatal_i,
    input  logic             data_valid_i,
    input  logic             ready_i,
    input  logic             reg_wr_i,
    input  logic             reg_addr_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    output logic [EW-1:0]    err_vec_o,
    output logic             realign_req_o,
    output logic             irq_o
);
    st_vec_t set_w, status_w, enable_w;

    rxerr_event_map #(.LANES(LANES)) map_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .lane_pcs_err_i (lane_pcs_err_i),
        .lane_crc_err_i (lane_crc_err_i),
        .align_lost_i   (align_lost_i),
        .fifo_ovf_i     (fifo_ovf_i),
        .ecc_corr_i     (ecc_corr_i),
        .ecc_fatal_i    (ecc_fatal_i),
        .deskew_fatal_i (deskew_fatal_i),
        .data_valid_i   (data_valid_i),
        .ready_i        (ready_i),
        .set_o          (set_w),
        .err_vec_o      (err_vec_o),
        .realign_req_o  (realign_req_o)
    );

    rxerr_sticky_regs regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (set_w),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .wdata_i  (reg_wdata_i[ST_W-1:0]),
        .status_o (status_w),
        .enable_o (enable_w),
        .irq_o    (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        reg_rdata_o[ST_W-1:0] = reg_addr_i ? enable_w : status_w;
    end

    // R11: with all enables off the interrupt stays low
    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_w == '0) |-> !irq_o);

    // R8: a deskew failure is recorded as status only
    p_deskew_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_fatal_i |=> status_w[ST_DESKEW]);
endmodule

// File: tb/rxerr_status_top_tb_top.sv
`timescale 1ns/1ps
module rxerr_status_top_tb_top;
    localparam int LANES = 4;
    localparam int REG_W = 32;
    localparam int EW    = LANES + 5;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [LANES-1:0] pcs, crc;
    logic             align, fifo, corr, fatal, deskew, dvalid, rdy;
    logic             wr, addr;
    logic [REG_W-1:0] wdata, rdata;
    logic [EW-1:0]    errv;
    logic             realign, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rxerr_status_top #(.LANES(LANES), .REG_W(REG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lane_pcs_err_i(pcs), .lane_crc_err_i(crc),
        .align_lost_i(align), .fifo_ovf_i(fifo),
        .ecc_corr_i(corr), .ecc_fatal_i(fatal),
        .deskew_fatal_i(deskew), .data_valid_i(dvalid), .ready_i(rdy),
        .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .err_vec_o(errv),
        .realign_req_o(realign), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0] pcs;
        logic [3:0] crc;
        logic       align;
        logic       fifo;
        logic       corr;
        logic       fatal;
        logic [8:0] exp;
    } row_t;

    // error vector: [3:0] lanes, 4 align, 5 reserved, 6 fifo, 7 ecc corr, 8 ecc fatal
    localparam row_t TBL [6] = '{
        '{4'b0001, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 9'b000000001},
        '{4'b0000, 4'b1000, 1'b0, 1'b0, 1'b0, 1'b0, 9'b000001000},
        '{4'b0100, 4'b0100, 1'b1, 1'b0, 1'b0, 1'b0, 9'b000010100},
        '{4'b0000, 4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 9'b001000000},
        '{4'b0010, 4'b0000, 1'b0, 1'b0, 1'b1, 1'b1, 9'b110000010},
        '{4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 1'b0, 9'b000000000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        pcs = '0; crc = '0; align = 0; fifo = 0; corr = 0; fatal = 0;
        deskew = 0; dvalid = 0; rdy = 1; wr = 0; addr = 0; wdata = '0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic reg_write(input logic a, input logic [31:0] d);
        @(negedge clk); quiet(); wr = 1; addr = a; wdata = d;
        tick();
        @(negedge clk); wr = 0;
    endtask

    task automatic read_status(output logic [31:0] v);
        @(negedge clk); addr = 0; #0.5; v = rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        quiet();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #0.5;
        // R12 reset state
        chk("R12 errvec", 32'(errv), 0);
        chk("R12 realign/irq", {30'd0, realign, irq}, 0);
        chk("R12 status", rdata, 0);
        addr = 1; #0.5;
        chk("R12 enable", rdata, 0);

        // table walk: R1 R2 R3 R4 R5
        foreach (TBL[i]) begin
            @(negedge clk);
            quiet();
            pcs = TBL[i].pcs; crc = TBL[i].crc; align = TBL[i].align;
            fifo = TBL[i].fifo; corr = TBL[i].corr; fatal = TBL[i].fatal;
            tick();
            chk($sformatf("R1/R4/R5 row %0d errvec", i), 32'(errv), 32'(TBL[i].exp));
            chk($sformatf("R2 row %0d realign", i), 32'(realign), 32'(TBL[i].align));
        end
        // pulses gone once inputs return quiet (R1 R5)
        @(negedge clk); quiet(); tick();
        chk("R1/R5 pulse ends", 32'(errv), 0);

        // R3: every input high, reserved bit N+1 stays 0
        @(negedge clk); pcs = '1; crc = '1; align = 1; fifo = 1; corr = 1; fatal = 1;
        tick();
        chk("R3 reserved bit", 32'(errv[LANES+1]), 0);
        chk("R4 fifo high held", 32'(errv[LANES+2]), 1);
        @(negedge clk); quiet(); tick();

        // R6 sticky status: bits 0..5 set by the events above
        read_status(v);
        chk("R6 status after events", v, 32'h3F);

        // R9 clear all
        reg_write(0, 32'hFF);
        read_status(v);
        chk("R9 cleared", v, 0);

        // R7 data while ready high: no error
        @(negedge clk); quiet(); dvalid = 1; rdy = 1; tick();
        @(negedge clk); quiet(); #0.5;
        chk("R7 ready high no error", rdata, 0);
        // R7 data while ready low
        @(negedge clk); quiet(); dvalid = 1; rdy = 0; tick();
        @(negedge clk); quiet(); #0.5;
        chk("R7 data error bit7", rdata, 32'h80);

        // R8 deskew: status bit6 only
        @(negedge clk); quiet(); deskew = 1; tick();
        chk("R8 errvec untouched", 32'(errv), 0);
        @(negedge clk); quiet(); #0.5;
        chk("R8 status bit6", rdata, 32'hC0);

        // R9 partial clear and zero write
        reg_write(0, 32'h40);
        read_status(v);
        chk("R9 clear bit6 only", v, 32'h80);
        reg_write(0, 32'h00);
        read_status(v);
        chk("R9 zero write keeps", v, 32'h80);

        // R10 set wins over clear on bit0
        @(negedge clk); quiet(); pcs = 4'b0001; tick();
        @(negedge clk); quiet(); pcs = 4'b0001; wr = 1; addr = 0; wdata = 32'h01; tick();
        @(negedge clk); quiet(); #0.5;
        chk("R10 set beats clear", rdata, 32'h81);

        // R11 masking
        chk("R11 irq masked", 32'(irq), 0);
        reg_write(1, 32'h01);
        addr = 1; #0.5;
        chk("R11 enable readback", rdata, 32'h01);
        chk("R11 irq on", 32'(irq), 1);
        reg_write(0, 32'h01);
        #0.5;
        chk("R11 irq off after clear", 32'(irq), 0);
        read_status(v);
        chk("R11 unmasked bit remains", v, 32'h80);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule